// File: doc/BRIEF.md
# Memory Traffic Generator and Bit Checker

This block is a bus master that exercises an attached memory and reports, bit by bit, whether the memory returned what was stored. Each test loop has a write pass followed by a read pass. The write pass stores `NUM_WORDS` consecutive words starting at `BASE_ADDR`. The read pass fetches the same words in the same order. The data stored at each address is a deterministic function of that address and of the loop number. Because of this, the checker can rebuild the expected word for every returned read without keeping any copy of the data.

One user word carries a complete memory burst of `BEATS` beats, each `MEM_W` bits wide. For every bit of that word the block keeps two flags:

- a live flag that drops for a single cycle after a wrong word is returned;
- a sticky flag that latches the first drop.

Three summary flags sit on top of these: pass, fail and timeout. A parameter sets the number of loops. A value of zero makes the block loop forever, and in that case pass is never raised. A stalled slave or a read response that never arrives is caught by a watchdog counter.

Top module: `mem_traffic_checker`

## Requirements
- R1: The per-bit flag vectors are `MEM_W*BEATS` bits wide. Bit `beat*MEM_W + dq` covers data line `dq` of burst beat `beat`, with beat 0 first. With the defaults, bit 40 is line 8 of the second beat.
- R2: Beat `b` of the word at address `A` in loop `L` (loops counted from 0) holds the low `MEM_W` bits of `{A[15:0], L[7:0], b[7:0]} ^ 32'h5A5AC3C3`.
- R3: Each loop issues writes to `BASE_ADDR` .. `BASE_ADDR+NUM_WORDS-1` in ascending order, then reads of the same addresses in the same order. Write and read are never issued together. Burst count is 1 and every byte enable is 1.
- R4: While a command is presented and `memReady` is low, the command, its address and its write data stay unchanged. A command counts as accepted only in a cycle with `memReady` high.
- R5: In the cycle after a read response, `pnfLive` equals the bitwise XNOR of the returned word and the expected word. In the cycle after any other cycle, it is all ones.
- R6: `pnfSticky` starts all ones. Each bit clears in the cycle its live bit drops, and stays clear until reset.
- R7: `testFail` rises in the same cycle that any live bit drops, and then holds until reset. Checking continues after a failure.
- R8: With `LOOPS > 0`, `testPass` rises in the cycle after the last read response of loop `LOOPS-1`, provided no miscompare occurred. It then holds. It never rises once `testFail` is set.
- R9: With `LOOPS = 0` the loops repeat without end and `testPass` never rises.
- R10: An idle counter restarts on every accepted command and every read response. After `TIMEOUT_CYC` consecutive cycles without either, `testTimeout` rises and holds, and no further commands are issued.
- R11: After pass or timeout, no command is issued.
- R12: After reset, both flag vectors are all ones, the three summary flags are low, and the first loop number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memRead | output | 1 | Read command request |
| memWrite | output | 1 | Write command request |
| memAddr | output | ADDR_W | Word address of the command |
| memBurstCount | output | BC_W | Burst count, always 1 |
| memByteEn | output | MEM_W*BEATS/8 | Byte enables, all ones |
| memWriteData | output | MEM_W*BEATS | Write data word |
| memReadData | input | MEM_W*BEATS | Returned read word |
| memReadValid | input | 1 | Read word valid |
| memReady | input | 1 | Slave accepts the presented command |
| pnfLive | output | MEM_W*BEATS | Live per-bit pass flags |
| pnfSticky | output | MEM_W*BEATS | Latched per-bit pass flags |
| testPass | output | 1 | All loops finished with no error |
| testFail | output | 1 | A miscompare was seen |
| testTimeout | output | 1 | Generator stalled |

## Verification
Some relations are checked on every cycle:

- a command is held while the slave is not ready;
- a sticky flag is never set while its live flag is low;
- the live vector is all ones after a cycle without a response;
- fail holds once set, and follows any dropped live bit;
- commands go quiet after pass or timeout, and pass stays low in endless mode.

Other behaviour depends on what the memory returns, so only the bench scenarios show it:

- the exact data pattern, including the loop-number dependence;
- the beat-by-beat position of a corrupted bit;
- the cycle on which pass and timeout rise;
- continued checking after a failure.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int IDX_W  = 16;
  localparam int LOOP_W = 16;
  localparam logic [31:0] PAT_MIX = 32'h5A5A_C3C3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_READ, ST_DRAIN, ST_DONE, ST_STUCK
  } mtcState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              cmdValid;
    logic              rxCheck;
    logic [IDX_W-1:0]  cmdIdx;
    logic [IDX_W-1:0]  rxIdx;
    logic [LOOP_W-1:0] loopNum;
  } mtcStrobe_t;
endpackage

// File: rtl/mtc_ctrl.sv
module mtc_ctrl
  import mtc_pkg::*;
#(
  parameter int NUM_WORDS   = 64,
  parameter int LOOPS       = 4,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       memReady,
  input  logic       memReadValid,
  input  logic       errSeen,
  output logic       memRead,
  output logic       memWrite,
  output logic       testPass,
  output logic       testFail,
  output logic       testTimeout,
  output mtcStrobe_t ctl
);
  localparam logic [IDX_W-1:0]  IDX_LAST   = IDX_W'(NUM_WORDS - 1);
  localparam logic [LOOP_W-1:0] LOOP_FINAL = LOOP_W'(LOOPS - 1);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);

  mtcState_t         state;
  logic [IDX_W-1:0]  cmdIdx, rxIdx;
  logic [LOOP_W-1:0] loopNum;
  logic [TO_W-1:0]   idleCnt;
  logic              failQ, timeoutQ;
  logic              accept, rxHit, lastRx, finalLoop, running;

  always_comb begin
    memWrite  = (state == ST_WRITE);
    memRead   = (state == ST_READ);
    accept    = (memWrite || memRead) && memReady;
    rxHit     = memReadValid && (state == ST_READ || state == ST_DRAIN);
    lastRx    = rxHit && (rxIdx == IDX_LAST);
    finalLoop = (LOOPS != 0) && (loopNum == LOOP_FINAL);
    running   = (state != ST_DONE) && (state != ST_STUCK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cmdIdx   <= '0;
      rxIdx    <= '0;
      loopNum  <= '0;
      idleCnt  <= '0;
      failQ    <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      failQ <= failQ | errSeen;
      if (rxHit) rxIdx <= lastRx ? '0 : rxIdx + 1'b1;
      case (state)
        ST_IDLE:  state <= ST_WRITE;
        ST_WRITE: if (accept) begin
          if (cmdIdx == IDX_LAST) begin cmdIdx <= '0; state <= ST_READ; end
          else cmdIdx <= cmdIdx + 1'b1;
        end
        ST_READ: if (accept) begin
          if (cmdIdx == IDX_LAST) begin cmdIdx <= '0; state <= ST_DRAIN; end
          else cmdIdx <= cmdIdx + 1'b1;
        end
        ST_DRAIN: if (lastRx) begin
          loopNum <= loopNum + 1'b1;
          state   <= finalLoop ? ST_DONE : ST_WRITE;
        end
        default: ;
      endcase
      // watchdog: restart on any bus progress
      if (running) begin
        if (accept || rxHit) idleCnt <= '0;
        else if (idleCnt == TO_LAST) begin
          timeoutQ <= 1'b1;
          state    <= ST_STUCK;
        end else idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  assign testPass    = (state == ST_DONE) && !failQ;
  assign testFail    = failQ;
  assign testTimeout = timeoutQ;

  always_comb begin
    ctl          = '0;
    ctl.cmdValid = memRead || memWrite;
    ctl.rxCheck  = rxHit;
    ctl.cmdIdx   = cmdIdx;
    ctl.rxIdx    = rxIdx;
    ctl.loopNum  = loopNum;
  end

  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    testFail |=> testFail);
  assert_timeout_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    testTimeout |=> testTimeout && !memRead && !memWrite);
  assert_pass_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    testPass |=> testPass && !memRead && !memWrite);
  assert_endless_nopass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (LOOPS == 0) |-> !testPass);
endmodule

// File: rtl/mtc_datapath.sv
module mtc_datapath
  import mtc_pkg::*;
#(
  parameter int MEM_W     = 32,   // at most 32
  parameter int BEATS     = 8,
  parameter int ADDR_W    = 24,
  parameter int BASE_ADDR = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mtcStrobe_t               ctl,
  input  logic [MEM_W*BEATS-1:0]   memReadData,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [MEM_W*BEATS-1:0]   memWriteData,
  output logic [MEM_W*BEATS-1:0]   pnfLive,
  output logic [MEM_W*BEATS-1:0]   pnfSticky,
  output logic                     errSeen
);
  localparam int DATA_W = MEM_W * BEATS;

  logic [ADDR_W-1:0] rxAddr;
  logic [15:0]       cmdA16, rxA16;
  logic [DATA_W-1:0] expWord, bitOk;

  assign memAddr = ADDR_W'(BASE_ADDR) + ADDR_W'(ctl.cmdIdx);
  assign rxAddr  = ADDR_W'(BASE_ADDR) + ADDR_W'(ctl.rxIdx);
  assign cmdA16  = 16'(memAddr);
  assign rxA16   = 16'(rxAddr);

  // one lane of pattern per burst beat
  for (genvar b = 0; b < BEATS; b++) begin : gLane
    logic [31:0] wrMix, expMix;
    assign wrMix  = {cmdA16, ctl.loopNum[7:0], 8'(b)} ^ PAT_MIX;
    assign expMix = {rxA16,  ctl.loopNum[7:0], 8'(b)} ^ PAT_MIX;
    assign memWriteData[b*MEM_W +: MEM_W] = wrMix[MEM_W-1:0];
    assign expWord[b*MEM_W +: MEM_W]      = expMix[MEM_W-1:0];
  end

  assign bitOk   = ~(memReadData ^ expWord);
  assign errSeen = ctl.rxCheck && !(&bitOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pnfLive   <= '1;
      pnfSticky <= '1;
    end else if (ctl.rxCheck) begin
      pnfLive   <= bitOk;
      pnfSticky <= pnfSticky & bitOk;
    end else begin
      pnfLive   <= '1;
    end
  end

  assert_sticky_below_live_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pnfSticky & ~pnfLive) == '0);
  assert_live_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.rxCheck) |-> (&pnfLive));
endmodule

// File: rtl/mem_traffic_checker.sv
module mem_traffic_checker
  import mtc_pkg::*;
#(
  parameter int MEM_W       = 32,
  parameter int BEATS       = 8,
  parameter int ADDR_W      = 24,
  parameter int BC_W        = 4,
  parameter int BASE_ADDR   = 0,
  parameter int NUM_WORDS   = 64,
  parameter int LOOPS       = 4,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic                         clk,
  input  logic                         rstN,
  output logic                         memRead,
  output logic                         memWrite,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [BC_W-1:0]              memBurstCount,
  output logic [MEM_W*BEATS/8-1:0]     memByteEn,
  output logic [MEM_W*BEATS-1:0]       memWriteData,
  input  logic [MEM_W*BEATS-1:0]       memReadData,
  input  logic                         memReadValid,
  input  logic                         memReady,
  output logic [MEM_W*BEATS-1:0]       pnfLive,
  output logic [MEM_W*BEATS-1:0]       pnfSticky,
  output logic                         testPass,
  output logic                         testFail,
  output logic                         testTimeout
);
  mtcStrobe_t ctl;
  logic       errSeen;

  assign memBurstCount = BC_W'(1);
  assign memByteEn     = '1;

  mtc_ctrl #(.NUM_WORDS(NUM_WORDS), .LOOPS(LOOPS), .TIMEOUT_CYC(TIMEOUT_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .memReady(memReady), .memReadValid(memReadValid),
    .errSeen(errSeen), .memRead(memRead), .memWrite(memWrite),
    .testPass(testPass), .testFail(testFail), .testTimeout(testTimeout), .ctl(ctl)
  );

  mtc_datapath #(.MEM_W(MEM_W), .BEATS(BEATS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memReadData(memReadData),
    .memAddr(memAddr), .memWriteData(memWriteData),
    .pnfLive(pnfLive), .pnfSticky(pnfSticky), .errSeen(errSeen)
  );

  assert_hold_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memRead || memWrite) && !memReady |=>
      $stable(memRead) && $stable(memWrite) && $stable(memAddr) && $stable(memWriteData));
  assert_fail_on_pnf_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(&pnfLive) |-> testFail);
endmodule

// File: tb/tb_mem_traffic_checker.sv
module tb_mtc_model #(
  parameter int MEM_W = 32, parameter int BEATS = 8, parameter int ADDR_W = 24,
  parameter int BASE = 0, parameter int N = 8, parameter int LOOPS = 2,
  parameter int LIM = 64
) (
  input  logic clk, input logic rstN,
  input  logic memRead, input logic memWrite,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [MEM_W*BEATS-1:0] memWriteData,
  input  logic stallOn, input logic dropOn,
  input  int flipAt, input int flipBit,
  output logic [MEM_W*BEATS-1:0] rdData,
  output logic rdValid, output logic ready,
  output logic [MEM_W*BEATS-1:0] expPnf, output logic [MEM_W*BEATS-1:0] expSticky,
  output logic expFail, output logic expPass, output logic expTimeout,
  output int protoErrs, output int respCount
);
  localparam int DW = MEM_W * BEATS;
  typedef struct { logic [DW-1:0] d; int due; } rsp_t;
  logic [DW-1:0] mem [N];
  rsp_t q[$];
  int cyc = 0, wrSeq = 0, rdSeq = 0, idle = 0;
  logic done = 0, pend = 0, pRd = 0, pWr = 0;
  logic [ADDR_W-1:0] pAddr = '0;
  logic [DW-1:0] pData = '0;
  logic [7:0] lfsr = 8'h1;

  initial begin
    rdData = '0; rdValid = 0; ready = 1; expPnf = '1; expSticky = '1;
    expFail = 0; expPass = 0; expTimeout = 0; protoErrs = 0; respCount = 0;
  end

  function automatic logic [DW-1:0] pat(int a, int lp);
    logic [DW-1:0] w;
    logic [31:0] ai = a, li = lp;
    for (int b = 0; b < BEATS; b++) begin
      logic [31:0] v = {ai[15:0], li[7:0], 8'(b)} ^ 32'h5A5AC3C3;
      w[b*MEM_W +: MEM_W] = v[MEM_W-1:0];
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); cyc = 0; wrSeq = 0; rdSeq = 0; idle = 0; done = 0; pend = 0;
      rdValid <= 0; ready <= 1; expPnf <= '1; expSticky <= '1;
      expFail <= 0; expPass <= 0; expTimeout <= 0; respCount <= 0;
    end else begin
      logic acc, fl, tmo;
      logic [DW-1:0] mm, stk, d;
      int idx, rc;
      cyc++;
      acc = (memRead || memWrite) && ready;
      fl = expFail; tmo = expTimeout; stk = expSticky; rc = respCount;
      if (pend && (memRead !== pRd || memWrite !== pWr || memAddr !== pAddr ||
                   (pWr && memWriteData !== pData))) begin
        protoErrs++; $display("FAIL R4: command changed while stalled");
      end
      pend = (memRead || memWrite) && !ready;
      pRd = memRead; pWr = memWrite; pAddr = memAddr; pData = memWriteData;
      if ((done || tmo) && (memRead || memWrite)) begin
        protoErrs++; $display("FAIL R11: command after end of test");
      end
      if (memRead && memWrite) begin protoErrs++; $display("FAIL R3: read and write together"); end
      if (memWrite && ready) begin
        idx = int'(memAddr) - BASE;
        if (idx != wrSeq % N || memWriteData !== pat(int'(memAddr), wrSeq / N)) begin
          protoErrs++;
          $display("FAIL R2/R3: write addr %h data %h expected idx %0d data %h",
                   memAddr, memWriteData, wrSeq % N, pat(BASE + wrSeq % N, wrSeq / N));
        end
        if (idx >= 0 && idx < N) mem[idx] = memWriteData;
        wrSeq++;
      end
      if (memRead && ready) begin
        idx = int'(memAddr) - BASE;
        if (idx != rdSeq % N || wrSeq < (rdSeq / N + 1) * N) begin
          protoErrs++; $display("FAIL R3: read addr %h out of order", memAddr);
        end
        d = (idx >= 0 && idx < N) ? mem[idx] : '0;
        if (rdSeq == flipAt) d[flipBit] = ~d[flipBit];
        if (!dropOn) q.push_back('{d: d, due: cyc + 2});
        rdSeq++;
      end
      // reference for the flag outputs
      if (rdValid) begin
        mm = rdData ^ pat(BASE + rc % N, rc / N);
        expPnf <= ~mm;
        stk = stk & ~mm;
        if (mm != '0) fl = 1;
        rc++;
        if (LOOPS != 0 && rc == N * LOOPS) done = 1;
      end else expPnf <= '1;
      if (!done && !tmo) begin
        if (acc || rdValid) idle = 0;
        else if (idle == LIM - 1) tmo = 1;
        else idle++;
      end
      expSticky <= stk; expFail <= fl; expTimeout <= tmo; respCount <= rc;
      expPass <= done && !fl;
      if (q.size() > 0 && q[0].due <= cyc) begin
        rdValid <= 1; rdData <= q[0].d; void'(q.pop_front());
      end else rdValid <= 0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ready <= stallOn ? (lfsr[0] | lfsr[2]) : 1'b1;
    end
  end
endmodule

module tb_mem_traffic_checker;
  localparam int MEM_W = 32, BEATS = 8, ADDR_W = 24, BC_W = 4;
  localparam int BASE = 'h100, N = 8, LOOPS = 2, LIM = 64;
  localparam int DW = MEM_W * BEATS;

  logic clk = 0, rstN = 0;
  always #5 clk = ~clk;

  logic stallOn = 0, dropOn = 0;
  int flipAt = -1, flipBit = 0;
  int vectors = 0, misses = 0;
  logic cmpOn = 0;

  // instance with a loop count
  logic rdA, wrA, rvA, rdyA, passA, failA, toA, ePassA, eFailA, eToA;
  logic [ADDR_W-1:0] adA; logic [BC_W-1:0] bcA; logic [DW/8-1:0] beA;
  logic [DW-1:0] wdA, rdDA, pnfA, stA, ePnfA, eStA;
  int protoA, respA;
  // endless instance
  logic rdB, wrB, rvB, rdyB, passB, failB, toB, ePassB, eFailB, eToB;
  logic [ADDR_W-1:0] adB; logic [BC_W-1:0] bcB; logic [DW/8-1:0] beB;
  logic [DW-1:0] wdB, rdDB, pnfB, stB, ePnfB, eStB;
  int protoB, respB;

  mem_traffic_checker #(.MEM_W(MEM_W), .BEATS(BEATS), .ADDR_W(ADDR_W), .BC_W(BC_W),
    .BASE_ADDR(BASE), .NUM_WORDS(N), .LOOPS(LOOPS), .TIMEOUT_CYC(LIM)) dut (
    .clk(clk), .rstN(rstN), .memRead(rdA), .memWrite(wrA), .memAddr(adA),
    .memBurstCount(bcA), .memByteEn(beA), .memWriteData(wdA), .memReadData(rdDA),
    .memReadValid(rvA), .memReady(rdyA), .pnfLive(pnfA), .pnfSticky(stA),
    .testPass(passA), .testFail(failA), .testTimeout(toA));
  tb_mtc_model #(.MEM_W(MEM_W), .BEATS(BEATS), .ADDR_W(ADDR_W), .BASE(BASE), .N(N),
    .LOOPS(LOOPS), .LIM(LIM)) mdlA (
    .clk(clk), .rstN(rstN), .memRead(rdA), .memWrite(wrA), .memAddr(adA),
    .memWriteData(wdA), .stallOn(stallOn), .dropOn(dropOn), .flipAt(flipAt),
    .flipBit(flipBit), .rdData(rdDA), .rdValid(rvA), .ready(rdyA), .expPnf(ePnfA),
    .expSticky(eStA), .expFail(eFailA), .expPass(ePassA), .expTimeout(eToA),
    .protoErrs(protoA), .respCount(respA));

  mem_traffic_checker #(.MEM_W(MEM_W), .BEATS(BEATS), .ADDR_W(ADDR_W), .BC_W(BC_W),
    .BASE_ADDR(BASE), .NUM_WORDS(N), .LOOPS(0), .TIMEOUT_CYC(LIM)) dutInf (
    .clk(clk), .rstN(rstN), .memRead(rdB), .memWrite(wrB), .memAddr(adB),
    .memBurstCount(bcB), .memByteEn(beB), .memWriteData(wdB), .memReadData(rdDB),
    .memReadValid(rvB), .memReady(rdyB), .pnfLive(pnfB), .pnfSticky(stB),
    .testPass(passB), .testFail(failB), .testTimeout(toB));
  tb_mtc_model #(.MEM_W(MEM_W), .BEATS(BEATS), .ADDR_W(ADDR_W), .BASE(BASE), .N(N),
    .LOOPS(0), .LIM(LIM)) mdlB (
    .clk(clk), .rstN(rstN), .memRead(rdB), .memWrite(wrB), .memAddr(adB),
    .memWriteData(wdB), .stallOn(stallOn), .dropOn(dropOn), .flipAt(flipAt),
    .flipBit(flipBit), .rdData(rdDB), .rdValid(rvB), .ready(rdyB), .expPnf(ePnfB),
    .expSticky(eStB), .expFail(eFailB), .expPass(ePassB), .expTimeout(eToB),
    .protoErrs(protoB), .respCount(respB));

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) if (rstN && cmpOn) begin
    chk("R5", "dut pnfLive", pnfA, ePnfA);
    chk("R6", "dut pnfSticky", stA, eStA);
    chk("R7", "dut fail", DW'(failA), DW'(eFailA));
    chk("R8", "dut pass", DW'(passA), DW'(ePassA));
    chk("R10", "dut timeout", DW'(toA), DW'(eToA));
    chk("R5", "endless pnfLive", pnfB, ePnfB);
    chk("R6", "endless pnfSticky", stB, eStB);
    chk("R7", "endless fail", DW'(failB), DW'(eFailB));
    chk("R9", "endless pass", DW'(passB), DW'(ePassB));
    chk("R10", "endless timeout", DW'(toB), DW'(eToB));
  end

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
  endtask

  task automatic waitEnd(int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (passA || failA || toA) begin
        if (!passA && !toA && respA < N * LOOPS) continue;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++; $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int r0;
    // scenario 1: clean run with a stalling slave
    stallOn = 1;
    doReset();
    cmpOn = 1;
    chk("R12", "pnfLive after reset", pnfA, '1);
    chk("R12", "pnfSticky after reset", stA, '1);
    chk("R12", "flags after reset", DW'({passA, failA, toA}), '0);
    chk("R3", "burst count", DW'(bcA), DW'(1));
    chk("R3", "byte enables", DW'(beA), {(DW/8){1'b1}});
    waitEnd(3000);
    chk("R8", "pass after loops", DW'(passA), DW'(1));
    chk("R8", "no fail on clean run", DW'(failA), DW'(0));
    chk("R8", "all responses seen", DW'(respA), DW'(N * LOOPS));
    r0 = respB;
    repeat (300) @(negedge clk);
    chk("R11", "no extra reads after pass", DW'(respA), DW'(N * LOOPS));
    chk("R9", "endless keeps looping", DW'(respB > r0 && respB > N * LOOPS), DW'(1));
    chk("R9", "endless never passes", DW'(passB), DW'(0));
    // scenario 2: one corrupted bit in loop 1, word 3, beat 1, line 8
    stallOn = 0; flipAt = N + 3; flipBit = 1 * MEM_W + 8;
    doReset();
    waitEnd(3000);
    chk("R7", "fail after corrupted read", DW'(failA), DW'(1));
    chk("R8", "pass blocked by fail", DW'(passA), DW'(0));
    chk("R1", "sticky marks beat1 line8", stA, ~(DW'(1) << (MEM_W + 8)));
    chk("R5", "live restored", pnfA, '1);
    chk("R7", "endless fail", DW'(failB), DW'(1));
    r0 = respB;
    repeat (100) @(negedge clk);
    chk("R7", "checking continues after fail", DW'(respB > r0), DW'(1));
    // scenario 3: responses never come back
    flipAt = -1; dropOn = 1;
    doReset();
    waitEnd(3000);
    chk("R10", "timeout raised", DW'(toA), DW'(1));
    chk("R10", "no pass on timeout", DW'(passA), DW'(0));
    repeat (20) @(negedge clk);
    chk("R10", "endless timeout", DW'(toB), DW'(1));
    chk("R4", "protocol errors dut", DW'(protoA), DW'(0));
    chk("R4", "protocol errors endless", DW'(protoB), DW'(0));
    cmpOn = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule